// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM

A word memory with two fully independent access ports, called left and right, sharing one storage array of 16-bit words. Each port has its own active-low chip select, read/write line, output enable and two active-low byte-lane selects (upper lane bits 15:8, lower lane bits 7:0). The bidirectional data bus of each port is split into a write-data input, a read-data output and a two-bit lane-drive vector, one bit per lane, that stands for the output enable of the bus drivers. Accesses are synchronous to one clock: each port issues one access per cycle, writes take effect at the clock edge, and read data with its lane-drive bits appears in the cycle after the request.

When both ports touch the same word in one cycle and at least one of them writes, an arbiter raises a busy flag on the port that came to that word later and suppresses that port's write. A strap input selects master mode, where the busy flags are computed on-chip and driven out, or slave mode, where the busy outputs stay low and each port's write is instead blocked by an externally supplied busy input. This lets several instances be cascaded side by side into a wider word with one master arbitrating for all of them. The address width is a parameter: 13 bits gives the full 8K-word configuration, and a 4K-word use simply ties the top address bit low.

Top module: `dpr_bytelane_top`

## Requirements
- R1: A word written through either port is returned by a later read of that address through either port; read data and lane-drive bits appear in the cycle after the read request.
- R2: While a port's `cs_n` is high, that port writes nothing and its `drv` is 2'b00 and `rdata` is zero in the following cycle; after reset both are zero.
- R3: With `cs_n` low but both `ub_n` and `lb_n` high, the port writes nothing and drives no lane; such a port is also not counted as accessing any word.
- R4: On a write (`cs_n` low, `we_n` low), `ub_n` low stores `wdata[15:8]` and `lb_n` low stores `wdata[7:0]`, each independently; an unselected lane of the stored word keeps its old value.
- R5: On a read (`cs_n` low, `we_n` high, `oe_n` low), `drv[1]` is set for a selected upper lane and `drv[0]` for a selected lower lane in the next cycle; `rdata` carries the stored byte in every driven lane and zero in every undriven lane.
- R6: A read with `oe_n` high gives `drv` = 2'b00 and zero `rdata` in the next cycle.
- R7: Both ports reading the same word in one cycle both receive it, and no busy flag is raised.
- R8: In master mode (`master` high), when both ports access the same word in one cycle and at least one writes, exactly one `busy_out` is high in that same cycle: the port that has been at that word for fewer consecutive cycles; on equal standing the right port; no busy is raised otherwise.
- R9: The write of the port flagged busy is not performed in that cycle, while the other port's write is performed.
- R10: In slave mode (`master` low) both `busy_out` stay low and a port's write is suppressed while its `busy_in` is high, reads being unaffected; in master mode `busy_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all accesses |
| rst_n | input | 1 | Asynchronous active-low reset of output and arbitration registers |
| master | input | 1 | Strap: high computes and drives busy, low takes busy from outside |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left read/write: low writes, high reads |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper-lane select, active low |
| l_lb_n | input | 1 | Left lower-lane select, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data, zero in undriven lanes |
| l_drv | output | 2 | Left lane drive enables: bit 1 upper, bit 0 lower |
| l_busy_out | output | 1 | Left busy flag in master mode |
| l_busy_in | input | 1 | Left external busy in slave mode |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right read/write: low writes, high reads |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper-lane select, active low |
| r_lb_n | input | 1 | Right lower-lane select, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data, zero in undriven lanes |
| r_drv | output | 2 | Right lane drive enables: bit 1 upper, bit 0 lower |
| r_busy_out | output | 1 | Right busy flag in master mode |
| r_busy_in | input | 1 | Right external busy in slave mode |

## Verification
The check that two writes never land on one word in the same cycle is only made in master mode; in slave mode it relies on the external busy inputs to keep the two ports apart, so the stimulus in slave mode never lets both ports write one word unblocked. The control inputs are taken to be settled before each clock edge, and the stimulus changes them only on the falling edge. Reads are only issued to words written earlier, because the storage has no reset value, and the random phase first fills every address it uses before mixing reads, writes, lane patterns and collisions.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Decide which port yields when both sit on one word.
  // held_* : that port was on this same word in the previous cycle.
  // was_paired : both ports were together on this word last cycle.
  function automatic side_e pick_loser(input logic held_l, input logic held_r,
                                       input logic was_paired, input side_e last);
    if (held_l && held_r && was_paired) return last;
    if (held_l && !held_r) return SIDE_RIGHT;
    if (held_r && !held_l) return SIDE_LEFT;
    return SIDE_RIGHT;
  endfunction

endpackage

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl #(
  parameter  int LANE_W = 8,
  localparam int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  output logic              act,
  output logic              wr,
  output logic [LANES-1:0]  rd_lanes,
  output logic [DATA_W-1:0] wr_mask,
  output logic [LANES-1:0]  drv
);

  logic [LANES-1:0] sel;
  logic             past_ok;

  assign sel      = {~ub_n, ~lb_n};
  assign act      = ~cs_n & (|sel);
  assign wr       = act & ~we_n;
  assign rd_lanes = (act & we_n & ~oe_n) ? sel : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_mask[g*LANE_W +: LANE_W] = {LANE_W{wr & sel[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv     <= '0;
      past_ok <= 1'b0;
    end else begin
      drv     <= rd_lanes;
      past_ok <= 1'b1;
    end
  end

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cs_n)) |-> (drv == '0));

  assert_no_lane_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ub_n && lb_n)) |-> (drv == '0));

  assert_oe_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(oe_n)) |-> (drv == '0));

  assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(we_n)) |-> (drv == '0));

endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              act_l,
  input  logic              wr_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              busy_in_l,
  input  logic              act_r,
  input  logic              wr_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              busy_in_r,
  output logic              busy_out_l,
  output logic              busy_out_r,
  output logic              wr_ok_l,
  output logic              wr_ok_r
);

  logic              last_act_l, last_act_r, last_paired;
  logic [ADDR_W-1:0] last_addr_l, last_addr_r;
  side_e             last_loser, loser;
  logic              held_l, held_r, paired, coll;
  logic              flag_l, flag_r, block_l, block_r;

  assign held_l = act_l & last_act_l & (addr_l == last_addr_l);
  assign held_r = act_r & last_act_r & (addr_r == last_addr_r);
  assign paired = act_l & act_r & (addr_l == addr_r);
  assign coll   = paired & (wr_l | wr_r);
  assign loser  = pick_loser(held_l, held_r, last_paired, last_loser);

  assign flag_l = coll & (loser == SIDE_LEFT);
  assign flag_r = coll & (loser == SIDE_RIGHT);

  assign busy_out_l = master & flag_l;
  assign busy_out_r = master & flag_r;
  assign block_l    = master ? flag_l : busy_in_l;
  assign block_r    = master ? flag_r : busy_in_r;
  assign wr_ok_l    = wr_l & ~block_l;
  assign wr_ok_r    = wr_r & ~block_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_act_l  <= 1'b0;
      last_act_r  <= 1'b0;
      last_addr_l <= '0;
      last_addr_r <= '0;
      last_paired <= 1'b0;
      last_loser  <= SIDE_RIGHT;
    end else begin
      last_act_l  <= act_l;
      last_act_r  <= act_r;
      last_addr_l <= addr_l;
      last_addr_r <= addr_r;
      last_paired <= paired;
      if (paired) last_loser <= loser;
    end
  end

  assert_single_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (master && act_l && act_r && (addr_l == addr_r) && (wr_l || wr_r))
      |-> ($countones({busy_out_l, busy_out_r}) == 1));

  assert_no_stray_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(act_l && act_r && (addr_l == addr_r))) |-> (!busy_out_l && !busy_out_r));

  assert_slave_busy_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!master) |-> (!busy_out_l && !busy_out_r));

  assert_no_dual_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (master && (addr_l == addr_r)) |-> !(wr_ok_l && wr_ok_r));

endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter  int ADDR_W = 10,
  parameter  int LANE_W = 8,
  localparam int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wmask,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic [LANES-1:0]  l_rlanes,
  output logic [DATA_W-1:0] l_rdata,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wmask,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic [LANES-1:0]  r_rlanes,
  output logic [DATA_W-1:0] r_rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  function automatic logic [DATA_W-1:0] spread(input logic [LANES-1:0] lanes);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{lanes[i]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
                                              input logic [DATA_W-1:0] new_w,
                                              input logic [DATA_W-1:0] mask);
    return (old_w & ~mask) | (new_w & mask);
  endfunction

  always_ff @(posedge clk) begin
    if (|l_wmask) store[l_addr] <= merge(store[l_addr], l_wdata, l_wmask);
    if (|r_wmask) store[r_addr] <= merge(store[r_addr], r_wdata, r_wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      l_rdata <= (|l_rlanes) ? (store[l_addr] & spread(l_rlanes)) : '0;
      r_rdata <= (|r_rlanes) ? (store[r_addr] & spread(r_rlanes)) : '0;
    end
  end

endmodule

// File: rtl/dpr_bytelane_top.sv
module dpr_bytelane_top #(
  parameter  int ADDR_W = 10,
  parameter  int LANE_W = 8,
  localparam int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic              l_ub_n,
  input  logic              l_lb_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic [LANES-1:0]  l_drv,
  output logic              l_busy_out,
  input  logic              l_busy_in,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic              r_ub_n,
  input  logic              r_lb_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic [LANES-1:0]  r_drv,
  output logic              r_busy_out,
  input  logic              r_busy_in
);

  logic              l_act, l_wr, l_wr_ok, r_act, r_wr, r_wr_ok;
  logic [LANES-1:0]  l_rd_lanes, r_rd_lanes;
  logic [DATA_W-1:0] l_wr_mask, r_wr_mask, l_drv_bits, r_drv_bits;

  dpr_port_ctl #(.LANE_W(LANE_W)) u_left (
    .clk(clk), .rst_n(rst_n), .cs_n(l_cs_n), .we_n(l_we_n), .oe_n(l_oe_n),
    .ub_n(l_ub_n), .lb_n(l_lb_n), .act(l_act), .wr(l_wr),
    .rd_lanes(l_rd_lanes), .wr_mask(l_wr_mask), .drv(l_drv)
  );

  dpr_port_ctl #(.LANE_W(LANE_W)) u_right (
    .clk(clk), .rst_n(rst_n), .cs_n(r_cs_n), .we_n(r_we_n), .oe_n(r_oe_n),
    .ub_n(r_ub_n), .lb_n(r_lb_n), .act(r_act), .wr(r_wr),
    .rd_lanes(r_rd_lanes), .wr_mask(r_wr_mask), .drv(r_drv)
  );

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .master(master),
    .act_l(l_act), .wr_l(l_wr), .addr_l(l_addr), .busy_in_l(l_busy_in),
    .act_r(r_act), .wr_r(r_wr), .addr_r(r_addr), .busy_in_r(r_busy_in),
    .busy_out_l(l_busy_out), .busy_out_r(r_busy_out),
    .wr_ok_l(l_wr_ok), .wr_ok_r(r_wr_ok)
  );

  dpr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_wmask(l_wr_mask & {DATA_W{l_wr_ok}}), .l_wdata(l_wdata),
    .l_rlanes(l_rd_lanes), .l_rdata(l_rdata),
    .r_addr(r_addr), .r_wmask(r_wr_mask & {DATA_W{r_wr_ok}}), .r_wdata(r_wdata),
    .r_rlanes(r_rd_lanes), .r_rdata(r_rdata)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_drv_bits
    assign l_drv_bits[g*LANE_W +: LANE_W] = {LANE_W{l_drv[g]}};
    assign r_drv_bits[g*LANE_W +: LANE_W] = {LANE_W{r_drv[g]}};
  end

  assert_left_quiet_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_rdata & ~l_drv_bits) == '0));

  assert_right_quiet_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((r_rdata & ~r_drv_bits) == '0));

endmodule

// File: tb/tb_dpr_bytelane_top.sv
module tb_dpr_bytelane_top;

  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst_n, master;
  logic        l_cs_n, l_we_n, l_oe_n, l_ub_n, l_lb_n, l_busy_in;
  logic        r_cs_n, r_we_n, r_oe_n, r_ub_n, r_lb_n, r_busy_in;
  logic [AW-1:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic [1:0]  l_drv, r_drv;
  logic        l_busy_out, r_busy_out;

  always #2 clk = ~clk;

  dpr_bytelane_top #(.ADDR_W(AW), .LANE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .master(master),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_ub_n(l_ub_n), .l_lb_n(l_lb_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drv(l_drv),
    .l_busy_out(l_busy_out), .l_busy_in(l_busy_in),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drv(r_drv),
    .r_busy_out(r_busy_out), .r_busy_in(r_busy_in)
  );

  int unsigned nchk = 0, nfail = 0;
  bit          finished = 0;

  // reference model state
  logic [15:0] ref_mem [int];
  int          cyc = 0, arr_l = 0, arr_r = 0;
  bit          was_l = 0, was_r = 0;
  int          prev_a_l = 0, prev_a_r = 0;
  logic [1:0]  x_l_drv = 0, x_r_drv = 0;
  logic [15:0] x_l_rd = 0, x_r_rd = 0;

  task automatic chk(input string req, input string what, input int unsigned act,
                     input int unsigned exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bytes_of(input logic [1:0] lanes);
    logic [15:0] m = 16'h0000;
    if (lanes[1]) m = m | 16'hFF00;
    if (lanes[0]) m = m | 16'h00FF;
    return m;
  endfunction

  // op: 0 idle, 1 write, 2 read, 3 read with output enable off; lanes {upper,lower}
  task automatic port_l(input int op, input logic [1:0] lanes, input int a, input logic [15:0] d);
    l_cs_n = (op == 0); l_we_n = (op != 1); l_oe_n = (op == 3);
    l_ub_n = ~lanes[1]; l_lb_n = ~lanes[0]; l_addr = AW'(a); l_wdata = d;
  endtask

  task automatic port_r(input int op, input logic [1:0] lanes, input int a, input logic [15:0] d);
    r_cs_n = (op == 0); r_we_n = (op != 1); r_oe_n = (op == 3);
    r_ub_n = ~lanes[1]; r_lb_n = ~lanes[0]; r_addr = AW'(a); r_wdata = d;
  endtask

  task automatic idle_both();
    port_l(0, 2'b11, 0, 16'h0);
    port_r(0, 2'b11, 0, 16'h0);
  endtask

  function automatic logic [15:0] peek(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  // One cycle: busy checked before the edge, registered outputs after it.
  task automatic tick(input string tag);
    bit al, ar, wl, wr, coll, right_later, bl, br, kl, kr;
    logic [1:0] sl, sr;
    int al_a, ar_a;
    #1;
    sl = {~l_ub_n, ~l_lb_n};
    sr = {~r_ub_n, ~r_lb_n};
    al = !l_cs_n && (sl != 2'b00);
    ar = !r_cs_n && (sr != 2'b00);
    wl = al && !l_we_n;
    wr = ar && !r_we_n;
    al_a = int'(l_addr);
    ar_a = int'(r_addr);
    if (al && !(was_l && prev_a_l == al_a)) arr_l = cyc;
    if (ar && !(was_r && prev_a_r == ar_a)) arr_r = cyc;
    coll = al && ar && (al_a == ar_a) && (wl || wr);
    right_later = (arr_r >= arr_l);
    bl = master && coll && !right_later;
    br = master && coll && right_later;
    chk(tag, "l_busy_out", l_busy_out, bl);
    chk(tag, "r_busy_out", r_busy_out, br);
    kl = master ? bl : l_busy_in;
    kr = master ? br : r_busy_in;
    x_l_drv = (al && l_we_n && !l_oe_n) ? sl : 2'b00;
    x_r_drv = (ar && r_we_n && !r_oe_n) ? sr : 2'b00;
    x_l_rd  = peek(al_a) & bytes_of(x_l_drv);
    x_r_rd  = peek(ar_a) & bytes_of(x_r_drv);
    if (wl && !kl) ref_mem[al_a] = (peek(al_a) & ~bytes_of(sl)) | (l_wdata & bytes_of(sl));
    if (wr && !kr) ref_mem[ar_a] = (peek(ar_a) & ~bytes_of(sr)) | (r_wdata & bytes_of(sr));
    was_l = al; prev_a_l = al_a;
    was_r = ar; prev_a_r = ar_a;
    cyc++;
    @(negedge clk);
    chk(tag, "l_drv", l_drv, x_l_drv);
    chk(tag, "r_drv", r_drv, x_r_drv);
    chk(tag, "l_rdata", l_rdata, x_l_rd);
    chk(tag, "r_rdata", r_rdata, x_r_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; master = 1'b1; l_busy_in = 1'b0; r_busy_in = 1'b0;
    idle_both();
    repeat (3) @(negedge clk);
    chk("R2", "reset l_drv", l_drv, 0);
    chk("R2", "reset r_drv", r_drv, 0);
    chk("R2", "reset l_rdata", l_rdata, 0);
    chk("R2", "reset r_rdata", r_rdata, 0);
    rst_n = 1'b1;
    tick("R2");

    // R1: full-word writes then reads from the other port
    port_l(1, 2'b11, 5, 16'hA1B2); port_r(1, 2'b11, 9, 16'h1234); tick("R1");
    port_l(2, 2'b11, 9, 16'h0);    port_r(2, 2'b11, 5, 16'h0);    tick("R1");
    // R7: both read the same word
    port_l(2, 2'b11, 5, 16'h0);    port_r(2, 2'b11, 5, 16'h0);    tick("R7");
    // R4: single-lane writes
    port_l(1, 2'b10, 5, 16'h7766); port_r(1, 2'b01, 9, 16'h55AA); tick("R4");
    // R5: single-lane reads
    port_l(2, 2'b10, 5, 16'h0);    port_r(2, 2'b01, 9, 16'h0);    tick("R5");
    port_l(2, 2'b11, 5, 16'h0);    port_r(2, 2'b11, 9, 16'h0);    tick("R4");
    // R3: chip selected but no lane selected
    port_l(1, 2'b00, 5, 16'h0000); port_r(2, 2'b00, 9, 16'h0);    tick("R3");
    // R2: deselected write attempt
    port_l(0, 2'b11, 5, 16'h0); l_cs_n = 1'b1; l_we_n = 1'b0;
    port_r(0, 2'b11, 9, 16'h0); r_cs_n = 1'b1; r_we_n = 1'b0; r_wdata = 16'hDEAD;
    tick("R2");
    // R6: output enable off
    port_l(3, 2'b11, 5, 16'h0);    port_r(3, 2'b11, 9, 16'h0);    tick("R6");
    port_l(2, 2'b11, 5, 16'h0);    port_r(2, 2'b11, 9, 16'h0);    tick("R3");

    // R8/R9: simultaneous arrival, both write: right yields, twice in a row
    port_l(1, 2'b11, 20, 16'h1111); port_r(1, 2'b11, 20, 16'h2222); tick("R8");
    port_l(1, 2'b11, 20, 16'h3333); port_r(1, 2'b11, 20, 16'h4444); tick("R9");
    port_l(2, 2'b11, 20, 16'h0);    idle_both(); port_l(2, 2'b11, 20, 16'h0); tick("R9");
    // left first, right joins with a write
    port_l(1, 2'b11, 30, 16'h0A0A); port_r(0, 2'b11, 0, 16'h0);     tick("R8");
    port_l(2, 2'b11, 30, 16'h0);    port_r(1, 2'b11, 30, 16'hBEEF); tick("R8");
    // right first reading, left joins with a write: left yields
    port_r(1, 2'b11, 40, 16'hC0DE); port_l(0, 2'b11, 0, 16'h0);     tick("R1");
    port_r(2, 2'b11, 40, 16'h0);    port_l(1, 2'b11, 40, 16'hFFFF); tick("R9");
    port_r(2, 2'b11, 40, 16'h0);    port_l(1, 2'b01, 40, 16'h1234); tick("R8");
    port_l(2, 2'b11, 40, 16'h0);    port_r(2, 2'b11, 30, 16'h0);    tick("R9");

    // R10: slave mode uses external busy
    master = 1'b0;
    l_busy_in = 1'b1;
    port_l(1, 2'b11, 60, 16'h6060); port_r(1, 2'b11, 61, 16'h6161); tick("R10");
    l_busy_in = 1'b0; r_busy_in = 1'b1;
    port_l(1, 2'b11, 62, 16'h6262); port_r(2, 2'b11, 61, 16'h0);    tick("R10");
    port_l(1, 2'b11, 70, 16'h7070); port_r(0, 2'b11, 0, 16'h0);     tick("R10");
    port_l(1, 2'b11, 70, 16'h7171); port_r(2, 2'b11, 70, 16'h0);    tick("R10");
    r_busy_in = 1'b0;
    port_l(2, 2'b11, 62, 16'h0);    port_r(2, 2'b11, 70, 16'h0);    tick("R10");
    // master ignores busy_in
    master = 1'b1; l_busy_in = 1'b1; r_busy_in = 1'b1;
    port_l(1, 2'b11, 63, 16'h6363); port_r(1, 2'b11, 64, 16'h6464); tick("R10");
    l_busy_in = 1'b0; r_busy_in = 1'b0;
    port_l(2, 2'b11, 64, 16'h0);    port_r(2, 2'b11, 63, 16'h0);    tick("R10");
    port_l(2, 2'b11, 60, 16'h0);    port_r(0, 2'b11, 0, 16'h0);     tick("R10");

    // random mix over a small address set, master mode
    for (int a = 0; a < 8; a++) begin
      port_l(1, 2'b11, a, 16'(a * 16'h1357)); port_r(0, 2'b11, 0, 16'h0); tick("R1");
    end
    for (int n = 0; n < 600; n++) begin
      port_l($urandom % 4, 2'($urandom), $urandom % 8, 16'($urandom));
      port_r($urandom % 4, 2'($urandom), $urandom % 8, 16'($urandom));
      tick("R8");
    end
    idle_both(); tick("R2");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule